// File: doc/BRIEF.md
# Reversible-Cell Lookahead Adder

This block adds two 4-bit operands and a carry-in and returns a 4-bit sum and a carry-out. It is purely combinational. The netlist is made only from reversible primitive cells: a three-line Peres cell, a three-line Toffoli cell and a two-line Feynman cell. Each cell has as many outputs as inputs, and no AND or OR gate appears anywhere. The carries are not rippled. Each slice forms a propagate term and a generate term, and each carry is built directly from all lower terms and the carry-in by the lookahead equation.

Reversible cells produce outputs that the arithmetic does not need. None of them is dropped. Every such output goes to a single `garbage` bus with a fixed layout, so that it stays observable.

Each bit position first passes through a Peres cell with a zero ancilla. This gives propagate on its middle line and generate on its last line. A lookahead unit for that position then builds the carry into the next position:
- Toffoli cells with zero targets form the AND products.
- Feynman cells combine the product terms with XOR.
- XOR is a valid replacement for OR here because at most one term can be 1.

A second Peres cell fed with (propagate, incoming carry, generate) gives the sum bit on its middle line. Its last line gives a locally rippled carry, which goes out on the garbage bus as a cross-check on the lookahead carry.

Top module: `revcla_adder`

## Requirements
- R1: For every combination of `op_a`, `op_b` and `carry_in`, the 5-bit value {`carry_out`, `sum`} equals `op_a + op_b + carry_in`.
- R2: When every bit position propagates (`op_a XOR op_b` is all ones), `carry_out` equals `carry_in` and every `sum` bit equals the inverse of `carry_in`.
- R3: The Peres cell maps (A,B,C) to (A, A XOR B, (A AND B) XOR C), and its eight input patterns give eight distinct output patterns.
- R4: The Toffoli cell maps (A,B,C) to (A, B, C XOR (A AND B)), and its eight input patterns give eight distinct output patterns.
- R5: The Feynman cell maps (A,B) to (A, A XOR B), and its four input patterns give four distinct output patterns.
- R6: The garbage bus is 5W(W-1)/2 + 6W bits wide, which is 54 bits for W=4. Slice i occupies 5i+6 bits starting at bit off(i) = 5i(i-1)/2 + 6i, and bit off(i) carries `op_a[i]`.
- R7: The top two bits of slice i hold fixed values. Bit off(i+1)-2 equals `op_a[i] XOR op_b[i]`. Bit off(i+1)-1 equals the carry into position i+1, which is (`op_a[i:0] + op_b[i:0] + carry_in`) shifted right by i+1. This rippled value always agrees with the lookahead carry.
- R8: With both operands and `carry_in` at zero, `sum`, `carry_out` and the whole garbage bus are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 (W) | First operand |
| op_b | input | 4 (W) | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 4 (W) | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |
| garbage | output | 54 (5W(W-1)/2+6W) | Unused outputs of all reversible cells, laid out by slice |

## Verification
The block has no registers, so every result is due in the same cycle as its stimulus, with zero cycles of latency. The bench drives the operands just after a rising edge and samples `sum`, `carry_out` and the garbage bits at the next falling edge. By then the combinational paths have settled, and no check depends on the order of events at the clock edge. The standalone cells are handled the same way: each pattern is driven after a rising edge and read half a cycle later.

// File: rtl/revcla_pkg.sv
`timescale 1ns/1ps
package revcla_pkg;

  // number of garbage lines a slice at bit position idx exports
  function automatic int garb_slice(input int idx);
    return 5 * idx + 6;
  endfunction

  // first garbage bit owned by slice idx
  function automatic int garb_offset(input int idx);
    return (5 * idx * (idx - 1)) / 2 + 6 * idx;
  endfunction

  // total garbage width for a w-bit adder
  function automatic int garb_total(input int w);
    return garb_offset(w);
  endfunction

  // garbage lines exported by the lookahead unit of slice idx
  function automatic int garb_lookahead(input int idx);
    return 5 * idx + 3;
  endfunction

endpackage

// File: rtl/rev_peres.sv
`timescale 1ns/1ps
module rev_peres (
  input  logic in_a,
  input  logic in_b,
  input  logic in_c,
  output logic out_p,
  output logic out_q,
  output logic out_r
);
  assign out_p = in_a;
  assign out_q = in_a ^ in_b;
  assign out_r = (in_a & in_b) ^ in_c;
endmodule

// File: rtl/rev_toffoli.sv
`timescale 1ns/1ps
module rev_toffoli (
  input  logic in_a,
  input  logic in_b,
  input  logic in_c,
  output logic out_x,
  output logic out_y,
  output logic out_z
);
  assign out_x = in_a;
  assign out_y = in_b;
  assign out_z = in_c ^ (in_a & in_b);
endmodule

// File: rtl/rev_feynman.sv
`timescale 1ns/1ps
module rev_feynman (
  input  logic in_a,
  input  logic in_b,
  output logic out_p,
  output logic out_q
);
  assign out_p = in_a;
  assign out_q = in_a ^ in_b;
endmodule

// File: rtl/revcla_carry_unit.sv
`timescale 1ns/1ps
// Lookahead carry into position IDX+1:
//   c = g[IDX] ^ sum_{k<IDX} (p[IDX:k+1] & g[k]) ^ (p[IDX:0] & cin)
// All terms are mutually exclusive, so XOR replaces OR.
// Garbage layout (ascending):
//   product Toffolis k = 0..IDX-1        : 2 lines each (x, y)
//   term Toffolis j = 0..IDX (IDX = cin) : 2 lines each (x, y)
//   Feynman accumulators j = 0..IDX      : 1 line each (p)
module revcla_carry_unit #(
  parameter int IDX = 0
) (
  input  logic [IDX:0]       prop,
  input  logic [IDX:0]       gen,
  input  logic               cin,
  output logic               cout,
  output logic [5*IDX+2:0]   garb
);
  localparam int TERM_BASE = 2 * IDX;
  localparam int FEYN_BASE = TERM_BASE + 2 * (IDX + 1);

  logic [IDX:0]   pp;    // pp[k] = prop[IDX] & ... & prop[k]
  logic [IDX:0]   trm;   // trm[j<IDX]: pp[j+1]&gen[j]; trm[IDX]: pp[0]&cin
  logic [IDX+1:0] acc;   // running XOR of terms

  assign pp[IDX] = prop[IDX];

  genvar k;
  generate
    for (k = 0; k < IDX; k++) begin : g_prod
      rev_toffoli u_prod (
        .in_a (pp[k+1]),
        .in_b (prop[k]),
        .in_c (1'b0),
        .out_x(garb[2*k]),
        .out_y(garb[2*k+1]),
        .out_z(pp[k])
      );
    end

    for (k = 0; k <= IDX; k++) begin : g_term
      if (k < IDX) begin : g_gen_term
        rev_toffoli u_term (
          .in_a (pp[k+1]),
          .in_b (gen[k]),
          .in_c (1'b0),
          .out_x(garb[TERM_BASE+2*k]),
          .out_y(garb[TERM_BASE+2*k+1]),
          .out_z(trm[k])
        );
      end else begin : g_cin_term
        rev_toffoli u_term (
          .in_a (pp[0]),
          .in_b (cin),
          .in_c (1'b0),
          .out_x(garb[TERM_BASE+2*k]),
          .out_y(garb[TERM_BASE+2*k+1]),
          .out_z(trm[k])
        );
      end
    end

    assign acc[0] = gen[IDX];
    for (k = 0; k <= IDX; k++) begin : g_acc
      rev_feynman u_acc (
        .in_a (trm[k]),
        .in_b (acc[k]),
        .out_p(garb[FEYN_BASE+k]),
        .out_q(acc[k+1])
      );
    end
  endgenerate

  assign cout = acc[IDX+1];
endmodule

// File: rtl/revcla_adder.sv
`timescale 1ns/1ps
// Slice i garbage (from off(i) upward):
//   [0]              operand copy of the input Peres cell (op_a[i])
//   [1 .. 5i+3]      lookahead unit lines
//   [5i+4]           propagate copy of the sum Peres cell
//   [5i+5]           locally rippled carry of the sum Peres cell
module revcla_adder #(
  parameter int W  = 4,
  parameter int GW = revcla_pkg::garb_total(W)
) (
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic          carry_in,
  output logic [W-1:0]  sum,
  output logic          carry_out,
  output logic [GW-1:0] garbage
);
  import revcla_pkg::*;

  logic [W-1:0] prop;         // a ^ b per position
  logic [W-1:0] gen;          // a & b per position
  logic [W:0]   carry;        // lookahead carries, carry[0] = carry_in
  logic [W-1:0] slice_carry;  // rippled carry from the sum Peres cell

  assign carry[0] = carry_in;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_slice
      localparam int OFF = garb_offset(i);
      localparam int LAW = garb_lookahead(i);

      rev_peres u_pg (
        .in_a (op_a[i]),
        .in_b (op_b[i]),
        .in_c (1'b0),
        .out_p(garbage[OFF]),
        .out_q(prop[i]),
        .out_r(gen[i])
      );

      revcla_carry_unit #(.IDX(i)) u_la (
        .prop(prop[i:0]),
        .gen (gen[i:0]),
        .cin (carry_in),
        .cout(carry[i+1]),
        .garb(garbage[OFF+1 +: LAW])
      );

      rev_peres u_sum (
        .in_a (prop[i]),
        .in_b (carry[i]),
        .in_c (gen[i]),
        .out_p(garbage[OFF+LAW+1]),
        .out_q(sum[i]),
        .out_r(slice_carry[i])
      );
      assign garbage[OFF+LAW+2] = slice_carry[i];
    end
  endgenerate

  assign carry_out = carry[W];
endmodule

// File: rtl/revcla_adder_chk.sv
`timescale 1ns/1ps
module revcla_adder_chk #(
  parameter int W  = 4,
  parameter int GW = revcla_pkg::garb_total(W)
) (
  input logic [W-1:0]  op_a,
  input logic [W-1:0]  op_b,
  input logic          carry_in,
  input logic [W-1:0]  sum,
  input logic          carry_out,
  input logic [GW-1:0] garbage,
  input logic [W-1:0]  prop,
  input logic [W-1:0]  la_carry,
  input logic [W-1:0]  slice_carry
);
  import revcla_pkg::*;

  always_comb begin
    assert_sum_R1: assert ({carry_out, sum} ==
        ({1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in}))
      else $error("R1 sum mismatch");

    if (&prop) begin
      assert_all_prop_R2: assert (carry_out == carry_in && sum == {W{~carry_in}})
        else $error("R2 all-propagate mismatch");
    end

    for (int i = 0; i < W; i++) begin
      assert_garb_copy_R6: assert (garbage[garb_offset(i)] == op_a[i])
        else $error("R6 garbage copy mismatch");
    end

    assert_slice_carry_R7: assert (slice_carry == la_carry)
      else $error("R7 ripple vs lookahead mismatch");

    if (op_a == '0 && op_b == '0 && !carry_in) begin
      assert_quiet_R8: assert (garbage == '0 && sum == '0 && !carry_out)
        else $error("R8 quiescent mismatch");
    end
  end
endmodule

bind revcla_adder revcla_adder_chk #(.W(W), .GW(GW)) u_chk (
  .op_a       (op_a),
  .op_b       (op_b),
  .carry_in   (carry_in),
  .sum        (sum),
  .carry_out  (carry_out),
  .garbage    (garbage),
  .prop       (prop),
  .la_carry   (carry[W:1]),
  .slice_carry(slice_carry)
);

// File: tb/tb_revcla_adder.sv
`timescale 1ns/1ps
module tb_revcla_adder;
  localparam int W  = 4;
  localparam int GW = 54;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [W-1:0]  op_a = '0, op_b = '0;
  logic          carry_in = 1'b0;
  logic [W-1:0]  sum;
  logic          carry_out;
  logic [GW-1:0] garbage;

  revcla_adder #(.W(W)) dut (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum(sum), .carry_out(carry_out), .garbage(garbage)
  );

  logic ca = 0, cb = 0, cc = 0;
  logic pp_p, pp_q, pp_r, tf_x, tf_y, tf_z, fy_p, fy_q;
  rev_peres   u_peres (.in_a(ca), .in_b(cb), .in_c(cc), .out_p(pp_p), .out_q(pp_q), .out_r(pp_r));
  rev_toffoli u_toff  (.in_a(ca), .in_b(cb), .in_c(cc), .out_x(tf_x), .out_y(tf_y), .out_z(tf_z));
  rev_feynman u_feyn  (.in_a(ca), .in_b(cb), .out_p(fy_p), .out_q(fy_q));

  // {a[13:10], b[9:6], cin[5], expected {cout,sum}[4:0]}
  localparam logic [13:0] VEC [8] = '{
    {4'd0,  4'd0,  1'b0, 5'd0},
    {4'd15, 4'd15, 1'b1, 5'd31},
    {4'd15, 4'd0,  1'b1, 5'd16},
    {4'd8,  4'd8,  1'b0, 5'd16},
    {4'd9,  4'd6,  1'b0, 5'd15},
    {4'd9,  4'd6,  1'b1, 5'd16},
    {4'd7,  4'd1,  1'b0, 5'd8},
    {4'd5,  4'd10, 1'b1, 5'd16}
  };

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 0;

  function automatic int goff(input int i);
    return (5 * i * (i - 1)) / 2 + 6 * i;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input int c);
    @(posedge clk);
    #0.5;
    op_a = W'(a); op_b = W'(b); carry_in = c[0];
    @(negedge clk);
  endtask

  // full port check of the current vector (R1, R6, R7)
  task automatic check_vec(input int a, input int b, input int c);
    int total;
    total = a + b + c;
    chk("R1 {cout,sum}", {27'd0, carry_out, sum}, total);
    for (int i = 0; i < W; i++) begin
      int m, rip;
      m   = (1 << (i + 1)) - 1;
      rip = ((a & m) + (b & m) + c) >> (i + 1);
      chk("R6 garbage operand copy", int'(garbage[goff(i)]), (a >> i) & 1);
      chk("R7 garbage propagate copy", int'(garbage[goff(i+1)-2]), ((a ^ b) >> i) & 1);
      chk("R7 garbage rippled carry", int'(garbage[goff(i+1)-1]), rip & 1);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    // quiescent state after start-up (R8)
    @(negedge clk);
    chk("R8 sum at zero", int'(sum), 0);
    chk("R8 carry_out at zero", int'(carry_out), 0);
    chk("R8 garbage at zero", int'(garbage == '0), 1);
    chk("R6 garbage width", $bits(garbage), 5 * W * (W - 1) / 2 + 6 * W);

    // table walk (R1)
    for (int v = 0; v < 8; v++) begin
      apply(int'(VEC[v][13:10]), int'(VEC[v][9:6]), int'(VEC[v][5]));
      chk("R1 table vector", {27'd0, carry_out, sum}, int'(VEC[v][4:0]));
    end

    // exhaustive sweep (R1, R6, R7)
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 2; c++) begin
          apply(a, b, c);
          check_vec(a, b, c);
        end

    // all-propagate corners (R2)
    apply(10, 5, 1);
    chk("R2 carry_out follows carry_in=1", int'(carry_out), 1);
    chk("R2 sum inverse of carry_in=1", int'(sum), 0);
    apply(3, 12, 0);
    chk("R2 carry_out follows carry_in=0", int'(carry_out), 0);
    chk("R2 sum inverse of carry_in=0", int'(sum), 15);

    // back to zero (R8)
    apply(0, 0, 0);
    chk("R8 garbage returns to zero", int'(garbage == '0), 1);

    // primitive cells, exhaustive (R3, R4, R5)
    begin
      logic [7:0] seen_p = '0, seen_t = '0;
      logic [3:0] seen_f = '0;
      for (int v = 0; v < 8; v++) begin
        logic a, b, c;
        a = v[2]; b = v[1]; c = v[0];
        @(posedge clk);
        #0.5;
        ca = a; cb = b; cc = c;
        @(negedge clk);
        chk("R3 peres outputs", int'({pp_p, pp_q, pp_r}), int'({a, a ^ b, (a & b) ^ c}));
        chk("R4 toffoli outputs", int'({tf_x, tf_y, tf_z}), int'({a, b, c ^ (a & b)}));
        seen_p[{pp_p, pp_q, pp_r}] = 1'b1;
        seen_t[{tf_x, tf_y, tf_z}] = 1'b1;
        if (!c) begin
          chk("R5 feynman outputs", int'({fy_p, fy_q}), int'({a, a ^ b}));
          seen_f[{fy_p, fy_q}] = 1'b1;
        end
      end
      chk("R3 peres bijective", int'(seen_p), 255);
      chk("R4 toffoli bijective", int'(seen_t), 255);
      chk("R5 feynman bijective", int'(seen_f), 15);
    end

    done = 1;
    finish_run();
  end
endmodule